// File: doc/BRIEF.md
# Unpacked Decimal Adjust Unit

This block corrects a 16-bit accumulator pair (a high byte and a low byte) that holds unpacked decimal digits, one digit per byte. A two-bit operation code selects one of four corrections: the fix-up after a binary addition, the fix-up after a binary subtraction, the split of a binary value into two digits after a multiply, and the merge of two digits into one binary value ahead of a divide. The numeric base is an input, normally driven with ten.

A one-cycle start pulse, taken while the unit is idle, captures the operation, both bytes, the incoming auxiliary carry and the base. The add, subtract and merge corrections finish on the next clock edge. The split runs as a restoring divide that produces one quotient bit per clock. When an operation completes, the unit writes the result bytes and the flags that this operation defines, and raises `done` for one cycle. The results then stay in place until the next operation completes. Flags that an operation does not define keep their previous values.

Top module: `decadj_unit`

## Requirements
- R1: While reset is held, and after it is released, every output is zero until the first operation completes. This covers both result bytes, all five flags, `div_err`, `done` and `busy`.
- R2: Op code 2'b00 is add-adjust. When the low nibble of the low byte is above 9, or `aux_in` is 1, the result low byte is (low nibble + 6) mod 16, the high byte is incremented modulo 256, and `flag_a` and `flag_c` are set to 1. Otherwise the low byte becomes its own low nibble, the high byte is unchanged, and both flags are cleared.
- R3: Op code 2'b01 is subtract-adjust. Under the same condition as R2, the result low byte is (low nibble − 6) mod 16, the high byte is decremented modulo 256, and `flag_a` and `flag_c` are set. Otherwise the low byte becomes its low nibble, the high byte is unchanged, and both flags are cleared.
- R4: After add-adjust or subtract-adjust, bits 7..4 of `res_lo` are zero.
- R5: Add-adjust and subtract-adjust change only `flag_a` and `flag_c`. `flag_z`, `flag_s` and `flag_p` keep their previous values.
- R6: Op code 2'b10 is split (multiply-adjust). With a nonzero base, `res_hi` = low byte / base and `res_lo` = low byte mod base, both unsigned.
- R7: Op code 2'b11 is merge (divide-adjust). `res_lo` = (base × high byte + low byte) mod 256, and `res_hi` = 0.
- R8: Split and merge set `flag_z` when `res_lo` is zero, copy bit 7 of `res_lo` to `flag_s`, and set `flag_p` when `res_lo` holds an even number of ones. `flag_a` and `flag_c` keep their previous values.
- R9: A split with base 0 finishes with `div_err` = 1. It returns both bytes unchanged and leaves all flags at their previous values. Every other completion drives `div_err` to 0.
- R10: Take the edge that samples `start` as edge 0. `done` is high after edge 1 for add, subtract, merge and a split with base 0. It is high after edge 8 for a split with a nonzero base.
- R11: `done` lasts exactly one cycle. The result bytes change only on a cycle in which `done` is high.
- R12: A `start` pulse is ignored while `busy` is high. The operation already running completes with its own operands, and no second completion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op | input | 2 | 00 add, 01 subtract, 10 split, 11 merge |
| acc_hi | input | 8 | Accumulator high byte |
| acc_lo | input | 8 | Accumulator low byte |
| aux_in | input | 1 | Incoming auxiliary-carry flag |
| base | input | 8 | Numeric base, normally 10 |
| res_hi | output | 8 | Result high byte |
| res_lo | output | 8 | Result low byte |
| flag_c | output | 1 | Carry flag |
| flag_a | output | 1 | Auxiliary-carry flag |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_p | output | 1 | Even-parity flag |
| div_err | output | 1 | Split attempted with base 0 |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in progress |

## Verification
The internal state is small: the captured operands, the partial remainder and quotient, and the step counter. Each part of it reaches the ports only at the `done` pulse of the operation it belongs to.

- A wrong step count would show first in the latency of `done` itself.
- A bad remainder or quotient bit would show as a wrong split digit or a wrong parity or zero flag on that same completion.
- A flag written when it should have held its value would show only as a mismatch against the value left by the previous operation.

For that reason the vectors are ordered so that each operation follows one that left distinct flags behind.

// File: rtl/decadj_unit.sv
module decadj_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] acc_hi,
  input  logic [W-1:0] acc_lo,
  input  logic         aux_in,
  input  logic [W-1:0] base,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo,
  output logic         flag_c,
  output logic         flag_a,
  output logic         flag_z,
  output logic         flag_s,
  output logic         flag_p,
  output logic         div_err,
  output logic         done,
  output logic         busy
);
  localparam int CW = $clog2(W + 1);
  localparam logic [1:0] OP_ADD = 2'b00, OP_SUB = 2'b01, OP_SPLIT = 2'b10, OP_MERGE = 2'b11;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [1:0]    op_q;
  logic [W-1:0]  hi_q, lo_q, base_q, rem_q, quo_q;
  logic          aux_q;
  logic [CW-1:0] cnt_q;

  // one restoring divide step per clock
  logic [W:0]   trial;
  logic         fits;
  logic [W-1:0] rem_nx, quo_nx;
  assign trial  = {rem_q, quo_q[W-1]};
  assign fits   = trial >= {1'b0, base_q};
  assign rem_nx = fits ? (trial[W-1:0] - base_q) : trial[W-1:0];
  assign quo_nx = {quo_q[W-2:0], fits};
  wire last_step = (cnt_q == CW'(W - 1));

  // nibble correction and merge
  wire          fix    = (lo_q[3:0] > 4'd9) | aux_q;
  wire [3:0]    nib_up = lo_q[3:0] + 4'd6;
  wire [3:0]    nib_dn = lo_q[3:0] - 4'd6;
  wire [W-1:0]  keep_lo = {{(W-4){1'b0}}, lo_q[3:0]};
  logic [W-1:0] mac_lo;
  assign mac_lo = base_q * hi_q + lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; div_err <= 1'b0;
      res_hi <= '0; res_lo <= '0;
      flag_c <= 1'b0; flag_a <= 1'b0; flag_z <= 1'b0; flag_s <= 1'b0; flag_p <= 1'b0;
      op_q <= OP_ADD; hi_q <= '0; lo_q <= '0; base_q <= '0; aux_q <= 1'b0;
      rem_q <= '0; quo_q <= '0; cnt_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          op_q <= op; hi_q <= acc_hi; lo_q <= acc_lo; base_q <= base; aux_q <= aux_in;
          rem_q <= '0; quo_q <= acc_lo; cnt_q <= '0;
        end
      end else begin
        case (op_q)
          OP_ADD, OP_SUB: begin
            res_lo  <= !fix ? keep_lo
                     : (op_q == OP_ADD) ? {{(W-4){1'b0}}, nib_up} : {{(W-4){1'b0}}, nib_dn};
            res_hi  <= !fix ? hi_q : (op_q == OP_ADD) ? hi_q + ONE : hi_q - ONE;
            flag_a  <= fix;
            flag_c  <= fix;
            div_err <= 1'b0;
            done    <= 1'b1;
            busy    <= 1'b0;
          end
          OP_SPLIT: begin
            if (base_q == '0) begin
              res_hi  <= hi_q;
              res_lo  <= lo_q;
              div_err <= 1'b1;
              done    <= 1'b1;
              busy    <= 1'b0;
            end else begin
              rem_q <= rem_nx;
              quo_q <= quo_nx;
              cnt_q <= cnt_q + CW'(1);
              if (last_step) begin
                res_hi  <= quo_nx;
                res_lo  <= rem_nx;
                flag_z  <= (rem_nx == '0);
                flag_s  <= rem_nx[W-1];
                flag_p  <= ~^rem_nx[7:0];
                div_err <= 1'b0;
                done    <= 1'b1;
                busy    <= 1'b0;
              end
            end
          end
          default: begin
            res_hi  <= '0;
            res_lo  <= mac_lo;
            flag_z  <= (mac_lo == '0);
            flag_s  <= mac_lo[W-1];
            flag_p  <= ~^mac_lo[7:0];
            div_err <= 1'b0;
            done    <= 1'b1;
            busy    <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/decadj_unit_chk.sv
module decadj_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         div_err,
  input logic         flag_z,
  input logic [W-1:0] res_hi,
  input logic [W-1:0] res_lo,
  input logic [1:0]   op_q,
  input logic [W-1:0] base_q
);
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r11_lo_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n) !$stable(res_lo) |-> done);
  a_r11_hi_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n) !$stable(res_hi) |-> done);
  a_r12_op_held: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(op_q));
  a_r12_accept_idle: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
  a_r4_digit: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !op_q[1]) |-> (res_lo[W-1:4] == '0));
  a_r7_hi_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == 2'b11) |-> (res_hi == '0));
  a_r9_zero_base: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == 2'b10 && base_q == '0) |-> div_err);
  a_r8_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q[1] && !div_err) |-> (flag_z == (res_lo == '0)));
endmodule

bind decadj_unit decadj_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .div_err(div_err), .flag_z(flag_z), .res_hi(res_hi), .res_lo(res_lo),
  .op_q(op_q), .base_q(base_q)
);

// File: tb/decadj_unit_tb.sv
module decadj_unit_tb;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, aux_in = 1'b0;
  logic [1:0] op = 2'b00;
  logic [7:0] acc_hi = '0, acc_lo = '0, base = 8'd10;
  logic [7:0] res_hi, res_lo;
  logic flag_c, flag_a, flag_z, flag_s, flag_p, div_err, done, busy;
  int checks = 0, fails = 0, lat = 0;
  logic ha = 0, hc = 0, hz = 0, hs = 0, hp = 0;

  always #4 clk = ~clk;

  decadj_unit u_dut (.clk(clk), .rst_n(rst_n), .start(start), .op(op), .acc_hi(acc_hi),
    .acc_lo(acc_lo), .aux_in(aux_in), .base(base), .res_hi(res_hi), .res_lo(res_lo),
    .flag_c(flag_c), .flag_a(flag_a), .flag_z(flag_z), .flag_s(flag_s), .flag_p(flag_p),
    .div_err(div_err), .done(done), .busy(busy));

  // {op, hi, lo, aux, base, exp_hi, exp_lo, exp_carry}
  localparam logic [43:0] VEC [22] = '{
    {2'd0, 8'h00, 8'h05, 1'b0, 8'd10, 8'h00, 8'h05, 1'b0},
    {2'd0, 8'h01, 8'h0C, 1'b0, 8'd10, 8'h02, 8'h02, 1'b1},
    {2'd0, 8'h02, 8'h03, 1'b1, 8'd10, 8'h03, 8'h09, 1'b1},
    {2'd0, 8'hFF, 8'h3A, 1'b0, 8'd10, 8'h00, 8'h00, 1'b1},
    {2'd2, 8'h00, 8'h3F, 1'b0, 8'd10, 8'h06, 8'h03, 1'b0},
    {2'd1, 8'h05, 8'h0F, 1'b0, 8'd10, 8'h04, 8'h09, 1'b1},
    {2'd1, 8'h03, 8'h02, 1'b1, 8'd10, 8'h02, 8'h0C, 1'b1},
    {2'd1, 8'h00, 8'h37, 1'b0, 8'd10, 8'h00, 8'h07, 1'b0},
    {2'd1, 8'h00, 8'h00, 1'b1, 8'd10, 8'hFF, 8'h0A, 1'b1},
    {2'd2, 8'h77, 8'h51, 1'b0, 8'd10, 8'h08, 8'h01, 1'b0},
    {2'd2, 8'h12, 8'hFF, 1'b0, 8'd10, 8'h19, 8'h05, 1'b0},
    {2'd2, 8'h00, 8'h09, 1'b0, 8'd10, 8'h00, 8'h09, 1'b0},
    {2'd2, 8'h00, 8'h00, 1'b0, 8'd10, 8'h00, 8'h00, 1'b0},
    {2'd2, 8'h00, 8'hAB, 1'b0, 8'd16, 8'h0A, 8'h0B, 1'b0},
    {2'd2, 8'h00, 8'hC8, 1'b0, 8'd1,  8'hC8, 8'h00, 1'b0},
    {2'd2, 8'h00, 8'hFF, 1'b0, 8'd255, 8'h01, 8'h00, 1'b0},
    {2'd3, 8'h07, 8'h03, 1'b0, 8'd10, 8'h00, 8'h49, 1'b0},
    {2'd3, 8'h09, 8'h09, 1'b0, 8'd10, 8'h00, 8'h63, 1'b0},
    {2'd3, 8'h0F, 8'h0F, 1'b0, 8'd10, 8'h00, 8'hA5, 1'b0},
    {2'd3, 8'h1A, 8'h04, 1'b0, 8'd10, 8'h00, 8'h08, 1'b0},
    {2'd3, 8'h00, 8'h00, 1'b0, 8'd10, 8'h00, 8'h00, 1'b0},
    {2'd3, 8'h03, 8'h02, 1'b0, 8'd16, 8'h00, 8'h32, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic even_ones(input logic [7:0] v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += int'(v[i]);
    return (c % 2) == 0;
  endfunction

  function automatic string op_tag(input logic [1:0] o);
    case (o)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic run_op(input logic [1:0] o, input logic [7:0] h, input logic [7:0] l,
                        input logic a, input logic [7:0] b);
    op = o; acc_hi = h; acc_lo = l; aux_in = a; base = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 outputs", {res_hi, res_lo, flag_c, flag_a, flag_z, flag_s, flag_p, div_err, done, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {res_hi, res_lo, flag_c, flag_a, flag_z, flag_s, flag_p, div_err, done, busy}, 0);

    foreach (VEC[i]) begin
      logic [1:0] o;
      logic [7:0] h, l, b, eh, el;
      logic ax, ec;
      {o, h, l, ax, b, eh, el, ec} = VEC[i];
      run_op(o, h, l, ax, b);
      chk("R10 latency", lat, (o == 2'd2) ? 9 : 2);
      chk(op_tag(o), {res_hi, res_lo}, {eh, el});
      chk("R9 no error", div_err, 0);
      if (!o[1]) begin
        chk("R4 high nibble", res_lo[7:4], 0);
        chk(op_tag(o), {flag_a, flag_c}, {ec, ec});
        chk("R5 held flags", {flag_z, flag_s, flag_p}, {hz, hs, hp});
        ha = ec; hc = ec;
      end else begin
        hz = (el == 8'h00); hs = el[7]; hp = even_ones(el);
        chk("R8 result flags", {flag_z, flag_s, flag_p}, {hz, hs, hp});
        chk("R8 held flags", {flag_a, flag_c}, {ha, hc});
      end
      @(negedge clk);
      chk("R11 done one cycle", done, 0);
      chk("R11 result stable", {res_hi, res_lo}, {eh, el});
    end

    // R9: split with base zero
    run_op(2'd2, 8'h12, 8'h34, 1'b0, 8'd0);
    chk("R10 zero-base latency", lat, 2);
    chk("R9 error flag", div_err, 1);
    chk("R9 bytes unchanged", {res_hi, res_lo}, 16'h1234);
    chk("R9 flags held", {flag_c, flag_a, flag_z, flag_s, flag_p}, {hc, ha, hz, hs, hp});

    // R12: second start during a split is ignored
    op = 2'd2; acc_hi = 8'h00; acc_lo = 8'h3F; aux_in = 1'b0; base = 8'd10; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R12 busy while running", busy, 1);
    op = 2'd0; acc_hi = 8'h40; acc_lo = 8'h0C; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 3;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk("R12 first op latency", lat, 9);
    chk("R12 first op result", {res_hi, res_lo}, 16'h0603);
    chk("R9 error cleared", div_err, 0);
    begin
      int extra = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk("R12 no second completion", extra, 0);
      chk("R11 idle hold", {res_hi, res_lo}, 16'h0603);
    end
    summary();
  end
endmodule